// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of an SDR-interface memory. It takes the memory from an undefined power-up state to a usable one. Once reset is released it owns the memory command pins and holds idle (NOP) commands for a settling interval of `SETTLE_CYC` clocks. It then closes every bank with one precharge-all and runs `REF_COUNT` auto-refresh commands. Finally it loads two configuration registers: the mode register and the extended register that carries the self-refresh array range and temperature rate. Both are written with values presented on input ports.

A static strap, `load_first`, moves both register loads so that they come straight after the precharge-all and ahead of the refreshes. Each command is followed by NOP cycles, so that the next command arrives exactly tRP, tRC or tMRD clocks later. When the last wait has elapsed, `init_done` rises and stays high until the next reset. Normal traffic, periodic refresh and the data path are handled elsewhere. The reset input is expected to be asserted asynchronously and already released in step with `clk`.

Top module: `sdram_init_seq`

## Requirements
- R1: After reset is released, the bus carries NOP (cs_n,ras_n,cas_n,we_n = 0,1,1,1) for exactly `SETTLE_CYC` rising edges, and the first other command appears after edge number `SETTLE_CYC`.
- R2: The first non-NOP command is precharge-all (0,0,1,0) with address bit 10 high, all other address bits low and bank address 0.
- R3: Exactly `REF_COUNT` auto-refresh commands (0,0,0,1) are issued, each with address and bank address zero; `REF_COUNT` is at least 2.
- R4: The mode register load is a load command (0,0,0,0) with bank address 0 and the address equal to `mode_word`.
- R5: The extended register load is a load command with bank address 2 and the address equal to `ext_word`, and it always comes directly after the mode register load.
- R6: With `load_first` low the order is precharge-all, all refreshes, mode load, extended load.
- R7: With `load_first` high the order is precharge-all, mode load, extended load, all refreshes.
- R8: The next command follows a precharge-all by exactly `TRP` cycles, a refresh by exactly `TRC` cycles and a register load by exactly `TMRD` cycles, with NOP in between.
- R9: Until `init_done` is high, CKE stays high, DQM stays high and the data output enable stays low.
- R10: `init_done` rises exactly one spacing interval (`TRC` or `TMRD`) after the last command, stays high until reset, and the bus shows only NOP from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| load_first | input | 1 | Strap: load both registers before the refreshes |
| mode_word | input | ADDR_W | Value written to the mode register |
| ext_word | input | ADDR_W | Value written to the extended register |
| mem_cke | output | 1 | Clock enable to memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dqm | output | 1 | Data mask |
| mem_dq_oe | output | 1 | Data bus output enable (always off here) |
| mem_addr | output | ADDR_W | Address bus |
| mem_ba | output | BA_W | Bank address |
| init_done | output | 1 | Initialization finished, sticky until reset |

## Verification
Several properties are checked on every cycle: the bus stays quiet during the settling window, the first command is a precharge-all with A10 high, and the two loads carry the right bank codes and words. They also cover the extended load never preceding the mode load, a NOP after every command, the pin levels before completion, a sticky done that brings a quiet bus, and the refresh total when done rises. The exact spacing of every command, the full order under each strap setting, and the cycle on which done rises can only be shown by the bench's scenarios. The bench compares each command against an expected queue built from the parameters.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [3:0] {
    ST_SETTLE,
    ST_PALL,
    ST_WAIT_RP,
    ST_REF,
    ST_WAIT_RC,
    ST_MRS,
    ST_WAIT_MRS,
    ST_EMRS,
    ST_WAIT_EMRS,
    ST_DONE
  } seq_state_e;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LOAD = 4'b0000,
    CMD_REF  = 4'b0001,
    CMD_PRE  = 4'b0010,
    CMD_NOP  = 4'b0111
  } bus_cmd_e;

endpackage

// File: rtl/init_wait_timer.sv
module init_wait_timer #(
  parameter int unsigned CW = 14,
  parameter logic [CW-1:0] RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign expired = (cnt_q == '0);
  assign cnt_en  = load || !expired;

  always_comb begin
    cnt_d = cnt_q;
    if (load)          cnt_d = load_val;
    else if (!expired) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= RST_VAL;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/init_cmd_drive.sv
module init_cmd_drive
  import sdram_init_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned BA_W   = 2
) (
  input  seq_state_e        state,
  input  logic [ADDR_W-1:0] mode_word,
  input  logic [ADDR_W-1:0] ext_word,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              dqm,
  output logic              dq_oe,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba
);

  localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << 10;
  localparam logic [BA_W-1:0]   BA_MODE   = '0;
  localparam logic [BA_W-1:0]   BA_EXT    = BA_W'(2);

  bus_cmd_e cmd;

  always_comb begin
    cmd  = CMD_NOP;
    addr = '0;
    ba   = '0;
    unique case (state)
      ST_PALL: begin cmd = CMD_PRE;  addr = ALL_BANKS; end
      ST_REF:  begin cmd = CMD_REF; end
      ST_MRS:  begin cmd = CMD_LOAD; addr = mode_word; ba = BA_MODE; end
      ST_EMRS: begin cmd = CMD_LOAD; addr = ext_word;  ba = BA_EXT;  end
      default: cmd = CMD_NOP;
    endcase
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign cke   = 1'b1;
  assign dqm   = 1'b1;
  assign dq_oe = 1'b0;

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int unsigned ADDR_W     = 13,
  parameter int unsigned BA_W       = 2,
  parameter int unsigned SETTLE_CYC = 12500,
  parameter int unsigned REF_COUNT  = 2,
  parameter int unsigned TRP        = 3,
  parameter int unsigned TRC        = 8,
  parameter int unsigned TMRD       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_first,
  input  logic [ADDR_W-1:0] mode_word,
  input  logic [ADDR_W-1:0] ext_word,
  output logic              mem_cke,
  output logic              mem_cs_n,
  output logic              mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_we_n,
  output logic              mem_dqm,
  output logic              mem_dq_oe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BA_W-1:0]   mem_ba,
  output logic              init_done
);

  localparam int unsigned GAP_MAX = (TRC > TRP) ? ((TRC > TMRD) ? TRC : TMRD)
                                                : ((TRP > TMRD) ? TRP : TMRD);
  localparam int unsigned T_MAX   = (SETTLE_CYC > GAP_MAX) ? SETTLE_CYC : GAP_MAX;
  localparam int unsigned CW      = $clog2(T_MAX + 1);
  localparam int unsigned RW      = $clog2(REF_COUNT + 1);
  localparam logic [CW-1:0] SETTLE_LD = CW'(SETTLE_CYC - 1);
  localparam logic [CW-1:0] RP_LD     = CW'(TRP - 2);
  localparam logic [CW-1:0] RC_LD     = CW'(TRC - 2);
  localparam logic [CW-1:0] MRD_LD    = CW'(TMRD - 2);

  seq_state_e    st_q, st_d;
  logic [RW-1:0] refs_q, refs_d;
  logic          regs_q, regs_d;
  logic          tmr_load, tmr_exp;
  logic [CW-1:0] tmr_val;

  init_wait_timer #(.CW(CW), .RST_VAL(SETTLE_LD)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
  );

  always_comb begin
    st_d     = st_q;
    refs_d   = refs_q;
    regs_d   = regs_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (st_q)
      ST_SETTLE:   if (tmr_exp) st_d = ST_PALL;
      ST_PALL:     begin tmr_load = 1'b1; tmr_val = RP_LD; st_d = ST_WAIT_RP; end
      ST_WAIT_RP:  if (tmr_exp) st_d = load_first ? ST_MRS : ST_REF;
      ST_REF: begin
        tmr_load = 1'b1;
        tmr_val  = RC_LD;
        refs_d   = refs_q - RW'(1);
        st_d     = ST_WAIT_RC;
      end
      ST_WAIT_RC: if (tmr_exp) begin
        if (refs_q != '0)  st_d = ST_REF;
        else if (regs_q)   st_d = ST_DONE;
        else               st_d = ST_MRS;
      end
      ST_MRS:      begin tmr_load = 1'b1; tmr_val = MRD_LD; st_d = ST_WAIT_MRS; end
      ST_WAIT_MRS: if (tmr_exp) st_d = ST_EMRS;
      ST_EMRS: begin
        tmr_load = 1'b1;
        tmr_val  = MRD_LD;
        regs_d   = 1'b1;
        st_d     = ST_WAIT_EMRS;
      end
      ST_WAIT_EMRS: if (tmr_exp) st_d = (refs_q != '0) ? ST_REF : ST_DONE;
      ST_DONE:     st_d = ST_DONE;
      default:     st_d = ST_SETTLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_SETTLE;
      refs_q <= RW'(REF_COUNT);
      regs_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      refs_q <= refs_d;
      regs_q <= regs_d;
    end
  end

  assign init_done = (st_q == ST_DONE);

  init_cmd_drive #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_drive (
    .state(st_q), .mode_word(mode_word), .ext_word(ext_word),
    .cke(mem_cke), .cs_n(mem_cs_n), .ras_n(mem_ras_n), .cas_n(mem_cas_n),
    .we_n(mem_we_n), .dqm(mem_dqm), .dq_oe(mem_dq_oe), .addr(mem_addr), .ba(mem_ba)
  );

endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
  parameter int unsigned ADDR_W     = 13,
  parameter int unsigned BA_W       = 2,
  parameter int unsigned SETTLE_CYC = 12500,
  parameter int unsigned REF_COUNT  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] mode_word,
  input logic [ADDR_W-1:0] ext_word,
  input logic              mem_cke,
  input logic              mem_cs_n,
  input logic              mem_ras_n,
  input logic              mem_cas_n,
  input logic              mem_we_n,
  input logic              mem_dqm,
  input logic              mem_dq_oe,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [BA_W-1:0]   mem_ba,
  input logic              init_done
);

  localparam int unsigned SC = $clog2(SETTLE_CYC + 1);
  localparam int unsigned RC = $clog2(REF_COUNT + 2);

  logic [3:0]    bus;
  logic          is_nop, is_pre, is_ref, is_load;
  logic [SC-1:0] settle_cnt;
  logic [RC-1:0] ref_cnt;
  logic          any_cmd, mrs_seen;

  assign bus     = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};
  assign is_nop  = (bus == 4'b0111);
  assign is_pre  = (bus == 4'b0010);
  assign is_ref  = (bus == 4'b0001);
  assign is_load = (bus == 4'b0000);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_cnt <= '0;
      ref_cnt    <= '0;
      any_cmd    <= 1'b0;
      mrs_seen   <= 1'b0;
    end else begin
      if (settle_cnt != SC'(SETTLE_CYC)) settle_cnt <= settle_cnt + SC'(1);
      if (is_ref)                        ref_cnt    <= ref_cnt + RC'(1);
      if (!is_nop)                       any_cmd    <= 1'b1;
      if (is_load && mem_ba == '0)       mrs_seen   <= 1'b1;
    end
  end

  // R1
  settle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (settle_cnt < SC'(SETTLE_CYC)) |-> is_nop);

  // R2
  first_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_cmd && !is_nop) |-> (is_pre && mem_addr[10]));

  // R3
  ref_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> (ref_cnt == RC'(REF_COUNT)));

  // R4
  mrs_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_load && mem_ba == '0) |-> (mem_addr == mode_word));

  // R5
  emrs_after_mrs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_load && mem_ba != '0) |-> (mrs_seen && mem_ba == BA_W'(2) && mem_addr == ext_word));

  // R8
  gap_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_nop |=> is_nop);

  // R9
  pins_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> (mem_cke && mem_dqm && !mem_dq_oe));

  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  // R10
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> is_nop);

endmodule

bind sdram_init_seq sdram_init_chk #(
  .ADDR_W(ADDR_W), .BA_W(BA_W), .SETTLE_CYC(SETTLE_CYC), .REF_COUNT(REF_COUNT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_word(mode_word), .ext_word(ext_word),
  .mem_cke(mem_cke), .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n),
  .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n), .mem_dqm(mem_dqm),
  .mem_dq_oe(mem_dq_oe), .mem_addr(mem_addr), .mem_ba(mem_ba), .init_done(init_done)
);

// File: tb/sim_sdram_init_seq.sv
module sim_sdram_init_seq;

  localparam int AW   = 13;
  localparam int BW   = 2;
  localparam int S    = 12500;
  localparam int NREF = 3;
  localparam int TRP  = 3;
  localparam int TRC  = 8;
  localparam int TMRD = 2;
  localparam logic [3:0] C_NOP = 4'b0111, C_PRE = 4'b0010, C_REF = 4'b0001, C_LD = 4'b0000;

  typedef struct {
    logic [3:0]    cmd;
    logic [AW-1:0] addr;
    logic [BW-1:0] ba;
    int            at;
    string         req;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_first = 1'b0;
  logic [AW-1:0] mode_word = '0, ext_word = '0;
  logic mem_cke, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, mem_dqm, mem_dq_oe, init_done;
  logic [AW-1:0] mem_addr;
  logic [BW-1:0] mem_ba;

  item_t q[$];
  int n_chk = 0, n_fail = 0;
  int e = 0, done_at = -1, exp_done = 0, pin_bad = 0;

  always #4 clk = ~clk;

  sdram_init_seq #(.ADDR_W(AW), .BA_W(BW), .SETTLE_CYC(S), .REF_COUNT(NREF),
                   .TRP(TRP), .TRC(TRC), .TMRD(TMRD)) u0 (
    .clk(clk), .rst_n(rst_n), .load_first(load_first), .mode_word(mode_word),
    .ext_word(ext_word), .mem_cke(mem_cke), .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n),
    .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n), .mem_dqm(mem_dqm), .mem_dq_oe(mem_dq_oe),
    .mem_addr(mem_addr), .mem_ba(mem_ba), .init_done(init_done)
  );

  task automatic chk(input bit ok, input string req, input string detail);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", req, detail);
    end
  endtask

  task automatic push(input logic [3:0] c, input logic [AW-1:0] a, input logic [BW-1:0] b,
                      input int at, input string req);
    item_t it;
    it.cmd = c; it.addr = a; it.ba = b; it.at = at; it.req = req;
    q.push_back(it);
  endtask

  // Monitor: pops expected commands and compares bus, fields and cycle.
  always @(negedge clk) begin
    if (!rst_n) e = 0;
    else begin
      logic [3:0] bus;
      e++;
      bus = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};
      if (!init_done && !(mem_cke && mem_dqm && !mem_dq_oe)) pin_bad++;
      if (bus != C_NOP) begin
        if (q.size() == 0)
          chk(1'b0, "R10", $sformatf("extra cmd %b at %0d, expected none", bus, e));
        else begin
          item_t it;
          it = q.pop_front();
          chk(bus == it.cmd && mem_addr == it.addr && mem_ba == it.ba && e == it.at, it.req,
              $sformatf("cmd %b addr %h ba %0d cyc %0d, expected %b %h %0d %0d",
                        bus, mem_addr, mem_ba, e, it.cmd, it.addr, it.ba, it.at));
        end
      end
      if (init_done && done_at < 0) done_at = e;
    end
  end

  task automatic run_seq(input bit strap, input logic [AW-1:0] mw, input logic [AW-1:0] xw);
    int t;
    string ord;
    rst_n = 1'b0;
    load_first = strap; mode_word = mw; ext_word = xw;
    q.delete();
    done_at = -1; pin_bad = 0;
    ord = strap ? "R7" : "R6";
    t = S;
    push(C_PRE, AW'(1) << 10, '0, t, "R1 R2 first cmd");
    t += TRP;
    if (!strap) begin
      for (int i = 0; i < NREF; i++) begin
        push(C_REF, '0, '0, t, "R3 R6 R8 refresh");
        t += TRC;
      end
    end
    push(C_LD, mw, BW'(0), t, strap ? "R4 R7 R8 mode load" : "R4 R6 R8 mode load");
    t += TMRD;
    push(C_LD, xw, BW'(2), t, strap ? "R5 R7 R8 ext load" : "R5 R6 R8 ext load");
    t += TMRD;
    if (strap) begin
      for (int i = 0; i < NREF; i++) begin
        push(C_REF, '0, '0, t, "R3 R7 R8 refresh");
        t += TRC;
      end
    end
    exp_done = t;
    repeat (3) @(negedge clk);
    // reset state
    chk({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} == C_NOP && !init_done &&
        mem_cke && mem_dqm && !mem_dq_oe, "R9",
        $sformatf("reset bus %b done %b cke %b dqm %b oe %b, expected 0111 0 1 1 0",
                  {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n}, init_done, mem_cke, mem_dqm, mem_dq_oe));
    #1 rst_n = 1'b1;
    for (int k = 0; k < S + 400 && !init_done; k++) @(negedge clk);
    repeat (40) @(negedge clk);
    chk(done_at == exp_done, "R10", $sformatf("done at %0d, expected %0d", done_at, exp_done));
    chk(init_done == 1'b1, "R10", $sformatf("done %b later, expected 1", init_done));
    chk(q.size() == 0, ord, $sformatf("%0d cmds missing, expected 0", q.size()));
    chk(pin_bad == 0, "R9", $sformatf("%0d bad pin cycles, expected 0", pin_bad));
  endtask

  initial begin
    run_seq(1'b0, 13'h0232, 13'h0015);
    run_seq(1'b1, 13'h0A47, 13'h0062);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 80000);
    chk(1'b0, "R10", "watchdog expired, expected sequence to finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule